// File: doc/BRIEF.md
# DRAM Refresh Interval Timer

This block sets the pace of DRAM refresh. An 8-bit up-counter advances on each cycle where a prescaler tick is high. It is compared in every cycle against a programmable limit held in a 16-bit constant register. When the counter equals the limit, three things happen in the same clock edge:

- the counter returns to zero;
- a sticky match flag is set;
- if refresh is enabled and the normal refresh mode is selected, a CAS-before-RAS refresh request is raised toward the DRAM controller.

An interrupt output follows the flag while the interrupt enable is set.

Software reaches the counter, the limit and a control/status register through a small register bus. The bus has a 2-bit address, a write strobe, a read strobe and combinational read data. The refresh request uses a valid/ready pair:

- `rfsh_req` is the valid signal and `rfsh_ack` is the ready signal.
- A transfer completes on a cycle where both are high.
- While `rfsh_ack` stays low the request holds high with no limit on the wait.
- Matches that occur while a request is pending merge into it; they are not counted or queued.

A power-on reset clears all state. The `standby` input freezes the block and keeps every register, the limit included, at its value.

Top module: `refresh_interval_timer`

## Requirements
- R1: While `por_n` is low, every register reads 0 (address 0 control/status, 1 counter, 2 limit, 3 unused), and `rfsh_req` and `irq` are 0.
- R2: The limit register (address 2) is 16 bits wide. Bits 7:0 are writable. Bits 15:8 always read 0, and writes to them are ignored.
- R3: The counter (address 1, bits 7:0) is compared with the limit in every cycle. On equality the counter loads 0. Otherwise it increments only when `tick` is high. A bus write to the counter takes precedence over both.
- R4: A match sets the flag (control/status bit 0), which stays set afterwards. Writing 1 to bit 0 never sets the flag.
- R5: A write of 0 to bit 0 clears the flag only if the preceding control/status access was a read that returned the flag as 1. A match in the same cycle as such a clearing write wins, and the flag stays 1.
- R6: A match raises `rfsh_req` only when refresh enable (bit 2) is 1 and refresh mode (bit 3) is 0.
- R7: `rfsh_req` stays high until a cycle with `rfsh_ack` high and then falls. Further matches while the request is pending are merged into it.
- R8: `irq` is high exactly while the flag and interrupt enable (bit 1) are both 1. It falls in the cycle after either is cleared.
- R9: While `standby` is high, ticks, matches, reads, writes and acknowledges have no effect. All state, the limit included, is held.
- R10: A limit of 0 matches in every cycle while the counter is 0, so the flag cannot be cleared. Limits 1 and 255 produce a match once the counter reaches them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| standby | input | 1 | Freeze all state while high |
| tick | input | 1 | Prescaler count enable |
| reg_addr | input | 2 | Register select: 0 control/status, 1 counter, 2 limit |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe; it arms the flag-clear sequence |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| rfsh_req | output | 1 | Refresh request (valid) |
| rfsh_ack | input | 1 | Refresh acknowledge (ready) |
| irq | output | 1 | Compare-match interrupt, level |

## Verification
The hardest case to reach from the ports is a clearing write to the flag that lands in exactly the cycle of a new match. The read that arms the clear has to come in an earlier cycle, and the match has to arrive exactly one cycle after a counter write that sets the counter equal to the limit. The bench builds this timing deliberately: it writes the counter to the limit value, reads the status once, and then schedules the clearing write to coincide with the next forced match. Merged refresh requests are reached by holding the acknowledge low across many fast matches. The limit-of-zero case is covered by parking the counter at 0.

// File: rtl/rit_pkg.sv
package rit_pkg;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CSR   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CNT   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_LIMIT = 2'd2;

  localparam int BIT_FLAG = 0;
  localparam int BIT_IE   = 1;
  localparam int BIT_EN   = 2;
  localparam int BIT_MODE = 3;

  typedef struct packed {
    logic mode;
    logic en;
    logic ie;
    logic flag;
  } csr_t;
endpackage

// File: rtl/rit_counter.sv
module rit_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             hold,
  input  logic             tick,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             match
);
  assign match = !hold && (count == limit);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      count <= '0;
    end else if (!hold) begin
      if (load_en)    count <= load_val;
      else if (match) count <= '0;
      else if (tick)  count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/rit_regs.sv
module rit_regs
  import rit_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              hold,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              match,
  output logic [CNT_W-1:0]  limit,
  output csr_t              csr
);
  logic armed;
  logic csr_we, csr_re, lim_we, clr_req;

  assign csr_we  = we && (addr == ADDR_CSR);
  assign csr_re  = re && (addr == ADDR_CSR);
  assign lim_we  = we && (addr == ADDR_LIMIT);
  assign clr_req = csr_we && armed && !wdata[BIT_FLAG];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      limit <= '0;
      csr   <= '0;
      armed <= 1'b0;
    end else if (!hold) begin
      if (lim_we) limit <= wdata[CNT_W-1:0];
      if (csr_we) begin
        csr.ie   <= wdata[BIT_IE];
        csr.en   <= wdata[BIT_EN];
        csr.mode <= wdata[BIT_MODE];
      end
      if (match)        csr.flag <= 1'b1;
      else if (clr_req) csr.flag <= 1'b0;
      if (csr_we)                  armed <= 1'b0;
      else if (csr_re && csr.flag) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/rit_refresh.sv
module rit_refresh (
  input  logic clk,
  input  logic por_n,
  input  logic hold,
  input  logic fire,
  input  logic ack,
  output logic req
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      req <= 1'b0;
    end else if (!hold) begin
      if (fire)            req <= 1'b1;
      else if (req && ack) req <= 1'b0;
    end
  end
endmodule

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer
  import rit_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              standby,
  input  logic              tick,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              rfsh_req,
  input  logic              rfsh_ack,
  output logic              irq
);
  localparam int PAD_W = DATA_W - CNT_W;
  localparam int CSR_W = $bits(csr_t);

  logic [CNT_W-1:0] count, limit;
  logic             match, cnt_we, fire;
  csr_t             csr;

  assign cnt_we = reg_we && (reg_addr == ADDR_CNT);

  rit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .por_n(por_n), .hold(standby), .tick(tick),
    .load_en(cnt_we), .load_val(reg_wdata[CNT_W-1:0]),
    .limit(limit), .count(count), .match(match)
  );

  rit_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .por_n(por_n), .hold(standby), .we(reg_we), .re(reg_re),
    .addr(reg_addr), .wdata(reg_wdata), .match(match),
    .limit(limit), .csr(csr)
  );

  assign fire = match && csr.en && !csr.mode;

  rit_refresh u_rf (
    .clk(clk), .por_n(por_n), .hold(standby), .fire(fire),
    .ack(rfsh_ack), .req(rfsh_req)
  );

  assign irq = csr.flag && csr.ie;

  always_comb begin
    case (reg_addr)
      ADDR_CSR:   reg_rdata = {{(DATA_W-CSR_W){1'b0}}, csr};
      ADDR_CNT:   reg_rdata = {{PAD_W{1'b0}}, count};
      ADDR_LIMIT: reg_rdata = {{PAD_W{1'b0}}, limit};
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rit_chk.sv
module rit_chk #(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              por_n,
  input logic              standby,
  input logic              match,
  input logic              cnt_we,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  limit,
  input logic              flag,
  input logic              en,
  input logic              mode,
  input logic              irq,
  input logic              req,
  input logic              ack,
  input logic [1:0]        addr,
  input logic [DATA_W-1:0] rdata
);
  // R3
  match_clears_chk: assert property (@(posedge clk) disable iff (!por_n)
    match && !cnt_we |=> count == '0);
  // R4
  flag_set_chk: assert property (@(posedge clk) disable iff (!por_n)
    match |=> flag);
  // R6
  req_gate_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(req) |-> $past(en && !mode));
  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    req && !ack |=> req);
  // R8
  irq_flag_chk: assert property (@(posedge clk) disable iff (!por_n)
    !flag |-> !irq);
  // R2
  limit_upper_chk: assert property (@(posedge clk) disable iff (!por_n)
    addr == 2'd2 |-> rdata[DATA_W-1:CNT_W] == '0);
  // R9
  standby_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    standby |=> $stable(limit) && $stable(count) && $stable(flag));
endmodule

bind refresh_interval_timer rit_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .por_n(por_n), .standby(standby), .match(match),
  .cnt_we(cnt_we), .count(count), .limit(limit), .flag(csr.flag),
  .en(csr.en), .mode(csr.mode), .irq(irq), .req(rfsh_req),
  .ack(rfsh_ack), .addr(reg_addr), .rdata(reg_rdata)
);

// File: tb/sim_refresh_interval_timer.sv
module sim_refresh_interval_timer;
  logic        clk = 1'b0;
  logic        por_n = 1'b0, standby = 1'b0, tick = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic        reg_we = 1'b0, reg_re = 1'b0, rfsh_ack = 1'b0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        rfsh_req, irq;

  always #5 clk = ~clk;

  refresh_interval_timer u0 (
    .clk(clk), .por_n(por_n), .standby(standby), .tick(tick),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_re(reg_re),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rfsh_req(rfsh_req), .rfsh_ack(rfsh_ack), .irq(irq)
  );

  int    checks = 0, failures = 0;
  string tag = "R1";
  bit    done = 1'b0;

  // behavioural reference state
  int m_cnt, m_lim;
  bit m_flag, m_ie, m_en, m_mode, m_armed, m_req;

  always @(posedge clk) begin
    if (!por_n) begin
      m_cnt = 0; m_lim = 0; m_flag = 0; m_ie = 0; m_en = 0; m_mode = 0;
      m_armed = 0; m_req = 0;
    end else if (!standby) begin
      bit hit, wcsr, rcsr, old_flag;
      hit = (m_cnt == m_lim);
      wcsr = reg_we && reg_addr == 2'd0;
      rcsr = reg_re && reg_addr == 2'd0;
      old_flag = m_flag;
      if (hit && m_en && !m_mode) m_req = 1;
      else if (m_req && rfsh_ack) m_req = 0;
      if (hit) m_flag = 1;
      else if (wcsr && m_armed && !reg_wdata[0]) m_flag = 0;
      if (wcsr) m_armed = 0;
      else if (rcsr && old_flag) m_armed = 1;
      if (wcsr) begin
        m_ie = reg_wdata[1]; m_en = reg_wdata[2]; m_mode = reg_wdata[3];
      end
      if (reg_we && reg_addr == 2'd1) m_cnt = reg_wdata[7:0];
      else if (hit) m_cnt = 0;
      else if (tick) m_cnt = (m_cnt + 1) % 256;
      if (reg_we && reg_addr == 2'd2) m_lim = reg_wdata[7:0];
    end
  end

  function automatic logic [15:0] exp_rdata(logic [1:0] a);
    case (a)
      2'd0: return {12'd0, m_mode, m_en, m_ie, m_flag};
      2'd1: return 16'(m_cnt);
      2'd2: return 16'(m_lim);
      default: return 16'd0;
    endcase
  endfunction

  task automatic chk(string t, logic [15:0] act, logic [15:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", t, act, expv);
    end
  endtask

  task automatic cmp();
    chk({tag, " rdata"}, reg_rdata, exp_rdata(reg_addr));
    chk({tag, " rfsh_req"}, 16'(rfsh_req), 16'(m_req));
    chk({tag, " irq"}, 16'(irq), 16'(m_flag && m_ie));
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    cmp();
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    step();
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a);
    reg_addr = a; reg_re = 1'b1;
    step();
    reg_re = 1'b0;
  endtask

  task automatic peek(logic [1:0] a, output logic [15:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic run(int n, int tick_pct, int ack_pct);
    for (int i = 0; i < n; i++) begin
      tick = ($urandom_range(99) < tick_pct);
      rfsh_ack = ($urandom_range(99) < ack_pct);
      step();
    end
    tick = 1'b0;
    rfsh_ack = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    // R1 reset state
    tag = "R1";
    repeat (3) step();
    for (int a = 0; a < 4; a++) begin
      peek(2'(a), v);
      chk("R1 reset register", v, 16'd0);
    end
    chk("R1 reset req", 16'(rfsh_req), 16'd0);
    chk("R1 reset irq", 16'(irq), 16'd0);
    por_n = 1'b1;
    step();

    // R2 upper limit bits ignored
    tag = "R2";
    wr(2'd2, 16'hABCD);
    peek(2'd2, v);
    chk("R2 limit upper bits", v, 16'h00CD);

    // R3 counting, limit 5, refresh on
    tag = "R3";
    wr(2'd2, 16'd5);
    wr(2'd0, 16'h0004);
    run(80, 50, 30);
    wr(2'd2, 16'd9);
    wr(2'd1, 16'd3);
    run(4, 0, 100);
    peek(2'd1, v);
    chk("R3 no tick no advance", v, 16'd3);

    // R5 clear protocol
    tag = "R5";
    wr(2'd0, 16'h0004);
    peek(2'd0, v);
    chk("R5 clear without read keeps flag", 16'(v[0]), 16'd1);
    rd(2'd0);
    wr(2'd0, 16'h0004);
    peek(2'd0, v);
    chk("R5 read then write 0 clears", 16'(v[0]), 16'd0);
    tag = "R4";
    rd(2'd0);
    wr(2'd0, 16'h0005);
    peek(2'd0, v);
    chk("R4 write 1 does not set flag", 16'(v[0]), 16'd0);
    tag = "R5";
    wr(2'd1, 16'd9);
    step();
    rd(2'd0);
    wr(2'd1, 16'd9);
    wr(2'd0, 16'h0004);
    peek(2'd0, v);
    chk("R5 match beats clear", 16'(v[0]), 16'd1);

    // R8 interrupt level
    tag = "R8";
    wr(2'd0, 16'h0006);
    chk("R8 irq high", 16'(irq), 16'd1);
    wr(2'd0, 16'h0004);
    chk("R8 irq falls on ie clear", 16'(irq), 16'd0);
    wr(2'd0, 16'h0006);
    rd(2'd0);
    wr(2'd0, 16'h0006);
    chk("R8 irq falls on flag clear", 16'(irq), 16'd0);

    // R6 gating
    tag = "R6";
    rfsh_ack = 1'b1; step(); rfsh_ack = 1'b0;
    wr(2'd2, 16'd2);
    wr(2'd0, 16'h000C);
    run(20, 100, 0);
    chk("R6 mode 1 no request", 16'(rfsh_req), 16'd0);
    wr(2'd0, 16'h0000);
    run(20, 100, 0);
    chk("R6 disabled no request", 16'(rfsh_req), 16'd0);

    // R7 hold and merge
    tag = "R7";
    wr(2'd2, 16'd1);
    wr(2'd0, 16'h0004);
    run(30, 100, 0);
    chk("R7 request held", 16'(rfsh_req), 16'd1);
    wr(2'd0, 16'h0000);
    rfsh_ack = 1'b1; step(); rfsh_ack = 1'b0;
    chk("R7 single ack clears merged", 16'(rfsh_req), 16'd0);
    run(40, 70, 40);

    // R10 limit 0, then 255, then 1
    tag = "R10";
    wr(2'd0, 16'h0004);
    wr(2'd2, 16'd0);
    wr(2'd1, 16'd0);
    run(10, 100, 100);
    rd(2'd0);
    wr(2'd0, 16'h0004);
    peek(2'd0, v);
    chk("R10 limit 0 flag uncleared", 16'(v[0]), 16'd1);
    peek(2'd1, v);
    chk("R10 limit 0 counter parked", v, 16'd0);
    wr(2'd2, 16'd255);
    rd(2'd0);
    wr(2'd0, 16'h0004);
    wr(2'd1, 16'd254);
    tick = 1'b1; step(); tick = 1'b0;
    peek(2'd1, v);
    chk("R10 counter reaches 255", v, 16'd255);
    step();
    peek(2'd1, v);
    chk("R10 wrap after 255 match", v, 16'd0);
    peek(2'd0, v);
    chk("R10 flag at 255", 16'(v[0]), 16'd1);
    wr(2'd2, 16'd1);
    run(40, 60, 50);

    // R9 standby freeze
    tag = "R9";
    wr(2'd2, 16'd200);
    standby = 1'b1;
    wr(2'd2, 16'h0033);
    run(10, 100, 100);
    peek(2'd2, v);
    chk("R9 limit kept in standby", v, 16'd200);
    standby = 1'b0;
    run(30, 100, 50);

    // R1 power-on reset clears limit
    tag = "R1";
    por_n = 1'b0;
    step();
    peek(2'd2, v);
    chk("R1 por clears limit", v, 16'd0);
    por_n = 1'b1;
    step();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule